// File: doc/BRIEF.md
# Quadrant-Direction Asynchronous FIFO Flag Generator

This block derives the full and empty flags of a dual-clock FIFO straight from the write-side and read-side Gray-coded pointers. It does not copy either pointer into the other clock domain. It splits the pointer space into four quadrants, using the two most significant Gray bits of each pointer. A direction bit records whether the writer last came up on the reader from behind (heading full) or moved one quadrant ahead of it (heading empty). When the two pointers become identical, that bit decides which flag applies.

The comparison yields two active-low indications. Each one presets a short flop chain in the clock domain that owns the flag. The owning side can only create the condition through its own pointer step, so the flag rises in step with that side's clock. The other side removes the condition by stepping its own pointer, and the release then shifts through the chain on the owner's clock. Pointer counters and the storage array sit outside this block; the block takes Gray pointers in and gives two flags out.

Top module: `qfifo_dirflags`

## Requirements
- R1: When the write pointer's top two Gray bits name the quadrant just before the read pointer's quadrant (quadrant order 00, 01, 11, 10, cyclic), the direction bit becomes "heading full" (1) without waiting for any clock.
- R2: When the write pointer's quadrant is the one just after the read pointer's quadrant, the direction bit becomes "heading empty" (0) without waiting for any clock.
- R3: While either reset is low, the direction bit is held at "heading empty". After both resets release with equal pointers, `empty_o` reads 1 and `full_o` reads 0.
- R4: Whenever the pointers are equal and the direction is "heading full", `full_o` is 1. This holds in the same write-clock cycle as the write step that made them equal, so the writer never overfills.
- R5: Whenever the pointers are equal and the direction is "heading empty", `empty_o` is 1. This holds in the same read-clock cycle as the read step that made them equal.
- R6: Once the pointers stop being equal-and-full, `full_o` returns to 0 at the FLAG_STAGES-th rising `wclk` edge after the change, and no later.
- R7: Once the pointers stop being equal-and-empty, `empty_o` returns to 0 at the FLAG_STAGES-th rising `rclk` edge after the change, and no later.
- R8: While `wrst_n` is low, `full_o` is held at 1.
- R9: The heading-full and heading-empty decodes are combinational and are never true at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low, asynchronous |
| wr_gray | input | ADDR_W | Write pointer in Gray code |
| full_o | output | 1 | Full flag, write domain |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low, asynchronous |
| rd_gray | input | ADDR_W | Read pointer in Gray code |
| empty_o | output | 1 | Empty flag, read domain |

## Verification
The bench runs writer and reader pointers on unrelated clocks and keeps a reference occupancy count. At every opportunity it checks three things: full is never missing at depth, empty is never missing at zero, and neither flag lingers past the release window. A design with swapped quadrant decodes would let the writer wrap straight past the reader, because full would never rise. A direction bit that did not clear on reset would report full at start-up. A flag chain of the wrong length would release early, showing a stale free slot, or late, which the release-window check catches. Sustained full-rate phases on both sides keep the pointers crossing quadrant boundaries back to back.

// File: rtl/qdf_pkg.sv
package qdf_pkg;

   typedef enum logic {
      DIR_EMPTY = 1'b0,
      DIR_FULL  = 1'b1
   } dir_e;

   // writer one quadrant behind the reader: heading full
   function automatic logic quad_behind(input logic w_hi, input logic w_lo,
                                        input logic r_hi, input logic r_lo);
      return (w_hi ^ r_lo) & ~(w_lo ^ r_hi);
   endfunction

   // writer one quadrant ahead of the reader: heading empty
   function automatic logic quad_ahead(input logic w_hi, input logic w_lo,
                                       input logic r_hi, input logic r_lo);
      return ~(w_hi ^ r_lo) & (w_lo ^ r_hi);
   endfunction

endpackage

// File: rtl/qdf_quad_cmp.sv
module qdf_quad_cmp
   import qdf_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] wr_gray,
   input  logic [ADDR_W-1:0] rd_gray,
   output logic              go_full,
   output logic              go_empty,
   output logic              ptr_match
);
   localparam int HI = ADDR_W - 1;
   localparam int LO = ADDR_W - 2;

   always_comb begin
      go_full   = quad_behind(wr_gray[HI], wr_gray[LO], rd_gray[HI], rd_gray[LO]);
      go_empty  = quad_ahead (wr_gray[HI], wr_gray[LO], rd_gray[HI], rd_gray[LO]);
      ptr_match = (wr_gray == rd_gray);
   end
endmodule

// File: rtl/qdf_dir_latch.sv
module qdf_dir_latch
   import qdf_pkg::*;
(
   input  logic clr_n,
   input  logic set_full,
   input  logic set_empty,
   output dir_e dir
);
   always_latch begin
      if (!clr_n)
         dir <= DIR_EMPTY;
      else if (set_full)
         dir <= DIR_FULL;
      else if (set_empty)
         dir <= DIR_EMPTY;
   end
endmodule

// File: rtl/qdf_flag_reg.sv
module qdf_flag_reg #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic set_n,
   output logic flag_o
);
   localparam int CW = $clog2(STAGES + 1);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge set_n) begin
            if (!set_n) chain <= 1'b1;
            else        chain <= 1'b0;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge set_n) begin
            if (!set_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], 1'b0};
         end
      end
   endgenerate

   assign flag_o = chain[STAGES-1];

   // edges seen since the preset last went away
   logic [CW-1:0] quiet_cnt;
   always_ff @(posedge clk or negedge set_n) begin
      if (!set_n)
         quiet_cnt <= '0;
      else if (quiet_cnt != CW'(STAGES))
         quiet_cnt <= quiet_cnt + 1'b1;
   end

   // R6, R7
   flag_release_chk: assert property (@(posedge clk) disable iff (!set_n)
      (quiet_cnt == CW'(STAGES)) |-> !flag_o);
endmodule

// File: rtl/qfifo_dirflags.sv
module qfifo_dirflags
   import qdf_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int FLAG_STAGES = 2
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic [ADDR_W-1:0] wr_gray,
   output logic              full_o,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic [ADDR_W-1:0] rd_gray,
   output logic              empty_o
);
   generate
      if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_addr
         $error("qfifo_dirflags: ADDR_W must lie in 2..30");
      end
      if (FLAG_STAGES < 1 || FLAG_STAGES > 8) begin : g_bad_stages
         $error("qfifo_dirflags: FLAG_STAGES must lie in 1..8");
      end
   endgenerate

   logic go_full, go_empty, ptr_match;
   logic rst_both_n;
   dir_e dir;
   logic afull_n, aempty_n, full_set_n;

   assign rst_both_n = wrst_n & rrst_n;

   qdf_quad_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .wr_gray   (wr_gray),
      .rd_gray   (rd_gray),
      .go_full   (go_full),
      .go_empty  (go_empty),
      .ptr_match (ptr_match)
   );

   qdf_dir_latch u_dir (
      .clr_n     (rst_both_n),
      .set_full  (go_full),
      .set_empty (go_empty),
      .dir       (dir)
   );

   assign afull_n    = ~(ptr_match & (dir == DIR_FULL));
   assign aempty_n   = ~(ptr_match & (dir == DIR_EMPTY));
   assign full_set_n = afull_n & wrst_n;

   qdf_flag_reg #(.STAGES(FLAG_STAGES)) u_full (
      .clk    (wclk),
      .set_n  (full_set_n),
      .flag_o (full_o)
   );

   qdf_flag_reg #(.STAGES(FLAG_STAGES)) u_empty (
      .clk    (rclk),
      .set_n  (aempty_n),
      .flag_o (empty_o)
   );

   // R9
   decode_excl_chk: assert property (@(posedge wclk) disable iff (!rst_both_n)
      !(go_full && go_empty));

   // R1
   dir_set_chk: assert property (@(posedge wclk) disable iff (!rst_both_n)
      go_full |-> (dir == DIR_FULL));

   // R2
   dir_clr_chk: assert property (@(posedge rclk) disable iff (!rst_both_n)
      go_empty |-> (dir == DIR_EMPTY));

   // R4
   full_on_match_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
      (ptr_match && dir == DIR_FULL) |-> full_o);

   // R5
   empty_on_match_chk: assert property (@(posedge rclk) disable iff (!rst_both_n)
      (ptr_match && dir == DIR_EMPTY) |-> empty_o);
endmodule

// File: tb/qfifo_dirflags_test.sv
`timescale 1ns/1ps
module qfifo_dirflags_test;
   localparam int AW     = 4;
   localparam int DEPTH  = 1 << AW;
   localparam int STAGES = 2;

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          wrst_n = 1'b0, rrst_n = 1'b0;
   logic [AW-1:0] wr_gray = '0, rd_gray = '0;
   logic          full_o, empty_o;

   qfifo_dirflags #(.ADDR_W(AW), .FLAG_STAGES(STAGES)) uut (
      .wclk    (wclk),
      .wrst_n  (wrst_n),
      .wr_gray (wr_gray),
      .full_o  (full_o),
      .rclk    (rclk),
      .rrst_n  (rrst_n),
      .rd_gray (rd_gray),
      .empty_o (empty_o)
   );

   always #2.0 wclk = ~wclk;   // 250 MHz
   always #3.3 rclk = ~rclk;   // unrelated read clock

   int checks = 0, fails = 0;
   int wcount = 0, rcount = 0;
   int wedges_since_rd = 100, redges_since_wr = 100;
   int wr_rate = 0, rd_rate = 0;
   int wcycles = 0;
   bit run = 1'b0, done = 1'b0;
   logic [AW-1:0] wbin = '0, rbin = '0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // writer with full-side reference checks
   initial begin
      forever begin
         bit do_w;
         int occ;
         @(negedge wclk);
         occ = wcount - rcount;
         if (run) begin
            check(occ <= DEPTH, "R4 no overfill", occ, DEPTH);
            if (occ == DEPTH) check(full_o == 1'b1, "R4 full at depth", full_o, 1);
            if (occ < DEPTH && wedges_since_rd >= STAGES)
               check(full_o == 1'b0, "R6 full released", full_o, 0);
         end
         do_w = run && (wr_rate > 0) && ($urandom_range(99) < wr_rate) && !full_o;
         @(posedge wclk);
         wcycles++;
         if (wedges_since_rd < 100) wedges_since_rd++;
         if (do_w) begin
            #0.05;
            wbin    = wbin + 1'b1;
            wr_gray = wbin ^ (wbin >> 1);
            wcount++;
            redges_since_wr = 0;
         end
      end
   end

   // reader with empty-side reference checks
   initial begin
      forever begin
         bit do_r;
         int occ;
         @(negedge rclk);
         occ = wcount - rcount;
         if (run) begin
            check(occ >= 0, "R5 no underrun", occ, 0);
            if (occ == 0) check(empty_o == 1'b1, "R5 empty at zero", empty_o, 1);
            if (occ > 0 && redges_since_wr >= STAGES)
               check(empty_o == 1'b0, "R7 empty released", empty_o, 0);
         end
         do_r = run && (rd_rate > 0) && ($urandom_range(99) < rd_rate) && !empty_o;
         @(posedge rclk);
         if (redges_since_wr < 100) redges_since_wr++;
         if (do_r) begin
            #0.07;
            rbin    = rbin + 1'b1;
            rd_gray = rbin ^ (rbin >> 1);
            rcount++;
            wedges_since_rd = 0;
         end
      end
   end

   // watchdog
   initial begin
      wait (wcycles >= 150000);
      check(1'b0, "watchdog", wcycles, 150000);
      finish_run();
   end

   initial begin
      #10.1;
      check(full_o == 1'b1, "R8 full held in write reset", full_o, 1);
      check(empty_o == 1'b1, "R3 empty during reset", empty_o, 1);
      #11.0;
      wrst_n = 1'b1;
      rrst_n = 1'b1;
      repeat (6) @(negedge rclk);
      check(full_o == 1'b0, "R3 full low after reset", full_o, 0);
      check(empty_o == 1'b1, "R3 empty after reset", empty_o, 1);
      run = 1'b1;

      // fill: writer crosses every quadrant up to the reader (R1)
      wr_rate = 100; rd_rate = 0;
      repeat (40) @(negedge wclk);
      check(wcount - rcount == DEPTH, "R1 filled to depth", wcount - rcount, DEPTH);
      check(full_o == 1'b1, "R1 R4 full with direction set", full_o, 1);
      @(negedge rclk);
      check(empty_o == 1'b0, "R7 not empty when full", empty_o, 0);

      // drain: reader catches up (R2)
      wr_rate = 0; rd_rate = 100;
      repeat (40) @(negedge rclk);
      check(wcount - rcount == 0, "R2 drained", wcount - rcount, 0);
      check(empty_o == 1'b1, "R2 R5 empty with direction cleared", empty_o, 1);
      @(negedge wclk);
      check(full_o == 1'b0, "R6 not full when empty", full_o, 0);

      // mixed traffic
      wr_rate = 70; rd_rate = 50;  repeat (4000) @(negedge wclk);
      wr_rate = 40; rd_rate = 90;  repeat (4000) @(negedge wclk);
      wr_rate = 100; rd_rate = 100; repeat (4000) @(negedge wclk);
      wr_rate = 95; rd_rate = 30;  repeat (3000) @(negedge wclk);
      wr_rate = 20; rd_rate = 100; repeat (3000) @(negedge wclk);

      run = 1'b0;
      check(checks > 1000, "R9 traffic exercised both decodes", checks, 1000);
      finish_run();
   end
endmodule